// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Front End

This block is the software-visible register file of a multi-channel IDE bus-master DMA engine. A host reaches it through a plain byte-wide port: one address, one write strobe with a data byte, and a combinational read-data byte that follows the address. Each channel owns an eight-byte window. The second channel's window begins eight bytes above the first.

Inside a window, one byte holds the command, one holds the status, and four bytes hold a 32-bit descriptor-table pointer. The status byte has three kinds of bits:

- Capability flags that software writes directly.
- Event flags that hardware sets and software clears by writing ones.
- An activity flag that only the command byte can change.

Hardware pulses from the data mover set the event flags. The block sends three things back to the data mover for each channel:

- A one-cycle start pulse.
- A direction level.
- The descriptor-table base address.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous reset, every command, status and pointer byte reads 0x00. `start_pulse`, `xfer_dir` and `desc_base` are all 0.
- R2: Address bits [3] choose the channel (0 = first, 1 = second). Bits [2:0] choose the byte in the window: 0 command, 2 status, 4..7 pointer bytes least significant first (4 = bits 7:0, 7 = bits 31:24).
- R3: Reading window offsets 1 or 3 returns 0xFF. Writing to them changes no register.
- R4: A write to the command byte stores the whole byte, and a read returns it. `xfer_dir` of that channel follows command bit 3.
- R5: Writing the command byte with bit 0 = 1 drives that channel's `start_pulse` high for exactly the one cycle after the write edge, and sets status bit 0. Writing it with bit 0 = 0 clears status bit 0 and gives no pulse.
- R6: A status write loads status bits 5 and 6 from the written data.
- R7: A status write leaves status bit 0 unchanged.
- R8: A status write clears status bits 1 and 2 where the data bit is 1, and leaves them where it is 0.
- R9: Status bits 3, 4 and 7 always read as 0.
- R10: An `evt_err` pulse sets status bit 1 and an `evt_irq` pulse sets status bit 2 of its channel. When such a pulse and a clearing status write meet in one cycle, the bit ends up set.
- R11: Pointer bytes keep written data, except that pointer bits 1:0 always read 0. `desc_base` presents each channel's pointer, channel c at bits [32c+31:32c].
- R12: A write to one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 4 | Byte address: channel and window offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `addr`, combinational |
| evt_err | input | 2 | Per-channel error event pulse |
| evt_irq | input | 2 | Per-channel drive-interrupt event pulse |
| start_pulse | output | 2 | Per-channel one-cycle start request |
| xfer_dir | output | 2 | Per-channel transfer direction (command bit 3) |
| desc_base | output | 64 | Descriptor-table base per channel, 32 bits each |

## Verification
The bench writes the status byte with all ones. A design that wrongly treats bits 1 and 2 as plain data, or that lets bit 0 or the reserved bits follow the data, reads back something other than 0x60.

It drives an error pulse in the same cycle as a clearing write. If clear-wins priority had been coded, the error flag would be lost.

It writes pointer byte 4 with all ones and also writes to the padding offsets. A missing alignment mask shows up as a 0xFF read-back. A decode that writes through the padding corrupts the command byte.

It times the start pulse to the single cycle after the command write. This exposes a level instead of a pulse, and a pulse fired by a write of bit 0 = 0.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int WIN_W   = 3;
    localparam int PTR_W   = 32;
    localparam int BYTE_W  = 8;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int ST_RUN  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;

    localparam logic [BYTE_W-1:0] PAD_READ   = 8'hFF;
    localparam logic [BYTE_W-1:0] PTR_LO_MSK = 8'hFC;

    typedef enum logic [1:0] {
        FLD_CMD,
        FLD_STAT,
        FLD_PTR,
        FLD_PAD
    } fld_e;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] stat;
        logic [PTR_W-1:0]  ptr;
    } chan_regs_t;

    function automatic fld_e field_of(input logic [WIN_W-1:0] ofs);
        if (ofs[2])
            return FLD_PTR;
        else if (ofs[0])
            return FLD_PAD;
        else if (ofs[1])
            return FLD_STAT;
        else
            return FLD_CMD;
    endfunction

    function automatic logic [BYTE_W-1:0] stat_after_write(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] wd
    );
        logic [BYTE_W-1:0] r;
        r      = '0;
        r[6:5] = wd[6:5];
        r[2:1] = cur[2:1] & ~wd[2:1];
        r[0]   = cur[0];
        return r;
    endfunction

endpackage

// File: rtl/bmdma_addr_dec.sv
module bmdma_addr_dec
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int AW     = CH_W + WIN_W
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    output logic [NUM_CH-1:0] ch_we,
    output logic [CH_W-1:0]   ch_idx,
    output logic              ch_valid,
    output fld_e              fld,
    output logic [1:0]        byte_sel
);

    assign ch_idx   = addr[AW-1:WIN_W];
    assign ch_valid = int'(ch_idx) < NUM_CH;
    assign fld      = field_of(addr[WIN_W-1:0]);
    assign byte_sel = addr[1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_we
        assign ch_we[g] = wr_en && (int'(ch_idx) == g);
    end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  fld_e              fld,
    input  logic [1:0]        byte_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              evt_err,
    input  logic              evt_irq,
    output chan_regs_t        regs,
    output logic              start_pulse,
    output logic              dir
);

    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] stat_q;
    logic [BYTE_W-1:0] stat_d;
    logic [PTR_W-1:0]  ptr_q;
    logic              go_q;
    logic [BYTE_W-1:0] ptr_byte;

    always_comb begin
        stat_d = stat_q;
        if (we && fld == FLD_STAT)
            stat_d = stat_after_write(stat_q, wdata);
        if (we && fld == FLD_CMD)
            stat_d[ST_RUN] = wdata[CMD_GO];
        if (evt_err)
            stat_d[ST_ERR] = 1'b1;
        if (evt_irq)
            stat_d[ST_IRQ] = 1'b1;
    end

    assign ptr_byte = (byte_sel == 2'd0) ? (wdata & PTR_LO_MSK) : wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stat_q <= '0;
            ptr_q  <= '0;
            go_q   <= 1'b0;
        end else begin
            stat_q <= stat_d;
            go_q   <= we && fld == FLD_CMD && wdata[CMD_GO];
            if (we && fld == FLD_CMD)
                cmd_q <= wdata;
            if (we && fld == FLD_PTR)
                ptr_q[byte_sel*BYTE_W +: BYTE_W] <= ptr_byte;
        end
    end

    assign regs.cmd    = cmd_q;
    assign regs.stat   = stat_q;
    assign regs.ptr    = ptr_q;
    assign start_pulse = go_q;
    assign dir         = cmd_q[CMD_DIR];

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW    = CH_W + WIN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NUM_CH-1:0]       evt_err,
    input  logic [NUM_CH-1:0]       evt_irq,
    output logic [NUM_CH-1:0]       start_pulse,
    output logic [NUM_CH-1:0]       xfer_dir,
    output logic [NUM_CH*PTR_W-1:0] desc_base
);

    logic [NUM_CH-1:0] ch_we;
    logic [CH_W-1:0]   ch_idx;
    logic              ch_valid;
    fld_e              fld;
    logic [1:0]        byte_sel;
    chan_regs_t        regs [NUM_CH];

    bmdma_addr_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .ch_we    (ch_we),
        .ch_idx   (ch_idx),
        .ch_valid (ch_valid),
        .fld      (fld),
        .byte_sel (byte_sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bmdma_chan u_chan (
            .clk         (clk),
            .rst         (rst),
            .we          (ch_we[g]),
            .fld         (fld),
            .byte_sel    (byte_sel),
            .wdata       (wdata),
            .evt_err     (evt_err[g]),
            .evt_irq     (evt_irq[g]),
            .regs        (regs[g]),
            .start_pulse (start_pulse[g]),
            .dir         (xfer_dir[g])
        );
        assign desc_base[g*PTR_W +: PTR_W] = regs[g].ptr;
    end

    always_comb begin
        rdata = PAD_READ;
        if (ch_valid) begin
            unique case (fld)
                FLD_CMD:  rdata = regs[ch_idx].cmd;
                FLD_STAT: rdata = regs[ch_idx].stat;
                FLD_PTR:  rdata = regs[ch_idx].ptr[byte_sel*BYTE_W +: BYTE_W];
                default:  rdata = PAD_READ;
            endcase
        end
    end

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW    = CH_W + WIN_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [AW-1:0]     addr,
    input logic [BYTE_W-1:0] wdata,
    input logic [BYTE_W-1:0] rdata,
    input logic [NUM_CH-1:0] evt_err,
    input logic [NUM_CH-1:0] start_pulse,
    input logic [NUM_CH-1:0] xfer_dir
);

    // R3
    pad_read_chk: assert property (@(posedge clk) disable iff (rst)
        addr[0] == 1'b1 && addr[2] == 1'b0 |-> rdata == PAD_READ);

    // R9
    stat_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        addr[2:0] == 3'd2 |-> (rdata & 8'h98) == 8'h00);

    // R11
    ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
        addr[2:0] == 3'd4 |-> rdata[1:0] == 2'b00);

    // R10
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(evt_err[0]) && addr == AW'(2) |-> rdata[ST_ERR]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5
        start_src_chk: assert property (@(posedge clk) disable iff (rst)
            start_pulse[g] |-> $past(wr_en && addr == AW'(g * 8) && wdata[CMD_GO]));

        // R4
        dir_src_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(xfer_dir[g]) |-> $past(wr_en && addr == AW'(g * 8)));
    end

endmodule

bind bmdma_regs bmdma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .evt_err     (evt_err),
    .start_pulse (start_pulse),
    .xfer_dir    (xfer_dir)
);

// File: tb/bmdma_regs_bench.sv
module bmdma_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  evt_err = '0;
    logic [1:0]  evt_irq = '0;
    logic [1:0]  start_pulse;
    logic [1:0]  xfer_dir;
    logic [63:0] desc_base;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bmdma_regs u_bmdma_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .evt_err     (evt_err),
        .evt_irq     (evt_irq),
        .start_pulse (start_pulse),
        .xfer_dir    (xfer_dir),
        .desc_base   (desc_base)
    );

    // {write addr, write data, read addr, expected read}
    localparam logic [23:0] VEC [0:13] = '{
        24'h008008,  // R4 command store
        24'h2FF260,  // R6 R8 R9 R7 status all-ones write
        24'h200200,  // R6 clear caps
        24'h4FF4FC,  // R11 low bits masked
        24'h7A57A5,  // R2 top pointer byte
        24'h1551FF,  // R3 pad reads FF
        24'h155008,  // R3 pad write ignored
        24'hA20A20,  // R2 second channel status
        24'h809809,  // R4 second channel command
        24'hC13A21,  // R5 run bit set by command
        24'hA00A01,  // R7 run bit kept on status write
        24'h300200,  // R12 ch0 untouched
        24'hD77C10,  // R11 byte 4 mask kept
        24'h800A00   // R5 run bit cleared
    };

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        check(64'(rdata), 64'(exp), req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(100000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd_chk(4'(a), (a % 2 == 1 && (a % 8) < 4) ? 8'hFF : 8'h00, "R1");
        end
        check(64'(start_pulse), 64'h0, "R1");
        check(64'(xfer_dir), 64'h0, "R1");
        check(desc_base, 64'h0, "R1");

        // vector table
        for (int i = 0; i < 14; i++) begin
            wr(VEC[i][23:20], VEC[i][19:12]);
            rd_chk(VEC[i][11:8], VEC[i][7:0], "R2");
        end
        check(64'(xfer_dir), 64'h1, "R4");
        check(desc_base, 64'h00007710_A50000FC, "R11");

        // R5 start pulse timing
        wr(4'h0, 8'h01);
        check(64'(start_pulse), 64'h1, "R5");
        @(negedge clk);
        check(64'(start_pulse), 64'h0, "R5");
        rd_chk(4'h2, 8'h01, "R5");
        wr(4'h0, 8'h00);
        check(64'(start_pulse), 64'h0, "R5");
        rd_chk(4'h2, 8'h00, "R5");

        // R10 events
        @(negedge clk);
        evt_irq = 2'b01;
        @(negedge clk);
        evt_irq = 2'b00;
        rd_chk(4'h2, 8'h04, "R10");
        evt_err = 2'b10;
        @(negedge clk);
        evt_err = 2'b00;
        rd_chk(4'hA, 8'h02, "R10");
        rd_chk(4'h2, 8'h04, "R12");
        wr(4'hA, 8'h02);
        rd_chk(4'hA, 8'h00, "R8");

        // R10 set beats clear in the same cycle
        @(negedge clk);
        addr    = 4'h2;
        wdata   = 8'h06;
        wr_en   = 1'b1;
        evt_err = 2'b01;
        @(negedge clk);
        wr_en   = 1'b0;
        evt_err = 2'b00;
        rd_chk(4'h2, 8'h02, "R10");

        // R8 zero data leaves event bit
        wr(4'h2, 8'h00);
        rd_chk(4'h2, 8'h00 | 8'h02, "R8");

        // R1 reset mid-run
        do_reset();
        rd_chk(4'h0, 8'h00, "R1");
        rd_chk(4'h2, 8'h00, "R1");
        rd_chk(4'h8, 8'h00, "R1");
        check(desc_base, 64'h0, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule